// File: doc/BRIEF.md
# Battery Capacity Learning Counter

This block keeps the charge bookkeeping of a rechargeable battery pack as three counters. The first is the charge still available. The second counts everything drained since the pack was last full. The third holds the learned full capacity. Its inputs are count strobes that an upstream converter derives from the sense-resistor voltage. Charge strobes are scaled here by a charge-efficiency factor that depends on the charge regime and the temperature band. Self-discharge is estimated here from a prescaled time tick, at a rate that is proportional to the available charge and that doubles with each 10 °C step of temperature.

The learned capacity is replaced only after a discharge that qualifies. That discharge must run from full to the end-of-discharge voltage with no valid charge in between, with little self-discharge during it, and at a temperature of 0 °C or above. A qualification flag follows these conditions. When the next charge arrives, the drain counter is copied into the learned capacity. Four status flags report the qualification, the latched empty condition, an ongoing valid charge and a fresh (replaced or reset) battery.

Top module: `charge_ledger`

## Requirements
- R1: `avail_cnt` increments by one per scaled charge count and decrements by one per discharge strobe or self-discharge count. It never rises above `learned_cap` through charging and never drops below zero. When an increment and a decrement fall in the same cycle, the decrement wins.
- R2: `drain_cnt` increments on every discharge strobe. It also increments on every self-discharge count taken while `avail_cnt` is nonzero. It saturates at all ones. It is cleared in any cycle where `avail_cnt` equals `learned_cap`; if a decrement falls in that cycle, it ends at 1.
- R3: `flag_qual` sets on a discharge strobe that arrives while `avail_cnt` equals `learned_cap`.
- R4: `flag_qual` clears in three cases. The first is when more than SD_LIMIT (4096) self-discharge counts have accumulated since `avail_cnt` last equalled `learned_cap`. The second is a valid charge, meaning the 257th scaled charge count since the last discharge strobe. The third is end-of-discharge detection while `temp_code` is below 4, that is, below 0 °C.
- R5: A scaled charge count that arrives while `flag_empty` and `flag_qual` are both set copies `drain_cnt` into `learned_cap` and clears `flag_qual`. No other event except a reset changes `learned_cap`.
- R6: `flag_empty` sets whenever `low_v_det` is high and stays set until a valid charge. That valid charge also forces `avail_cnt` to zero.
- R7: `flag_charging` sets on a valid charge and clears on a discharge strobe.
- R8: Each `chg_strobe` adds a percentage to a fractional accumulator, and a count is emitted each time the accumulator passes 100. From reset, n strobes at a constant percentage give floor(n·pct/100) counts. The percentages are as follows:
  - trickle (`fast_chg`=0): 80 for `temp_code` 0–6, 75 for codes 7–8, 70 for codes 9 and up;
  - fast (`fast_chg`=1): 95, 90 and 85 for the same code groups.
  Code k covers 10k−40 °C to 10k−30 °C.
- R9: While `sd_enable` is high, each `sd_tick` adds `avail_cnt` to a self-discharge accumulator. When the sum reaches a threshold, one self-discharge count is taken and the threshold is subtracted; the remainder is capped at the threshold minus 1. The threshold is 4·SD_DEN shifted right by s, where s = 0 for codes ≤4, s = code−4 for codes 5–10, and s = 7 for codes ≥11. With `sd_enable` low, ticks have no effect.
- R10: `rst` or `init_req` loads `learned_cap` with `full_count` and sets `avail_cnt` to 0, or to `full_count` when `load_full` is high. It also clears `drain_cnt`, `flag_qual`, `flag_empty` and `flag_charging`, and clears both accumulators.
- R11: `flag_replaced` sets on reset and clears once `avail_cnt` equals `learned_cap` or `flag_empty` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Synchronous reinitialisation request, same effect as rst |
| full_count | input | CW | Programmed full capacity in counts |
| load_full | input | 1 | At reset, start with available charge at full_count |
| sd_enable | input | 1 | Enables the self-discharge estimate |
| chg_strobe | input | 1 | One raw charge count |
| fast_chg | input | 1 | Charge regime: 1 fast, 0 trickle |
| dis_strobe | input | 1 | One discharge count |
| sd_tick | input | 1 | Prescaled self-discharge time tick |
| temp_code | input | 4 | Temperature step, 10 °C per code |
| low_v_det | input | 1 | Cell voltage below the end-of-discharge level |
| avail_cnt | output | CW | Available charge |
| drain_cnt | output | CW | Charge drained since last full |
| learned_cap | output | CW | Learned full capacity |
| flag_qual | output | 1 | Present discharge qualifies for learning |
| flag_empty | output | 1 | Latched end-of-discharge |
| flag_charging | output | 1 | Valid charge in progress |
| flag_replaced | output | 1 | Battery reset or replaced |

## Verification
The hardest clear condition to reach is the self-discharge limit. It needs more than 4096 self-discharge counts inside one qualified discharge, while the available charge stays above zero. The bench starts from a nearly full 60000-count pack at the hottest temperature code. There the threshold falls to 40, so every tick yields exactly one count. A single discharge strobe arms the flag first. The bench then counts ticks to 4096, where the flag must still be set, and then to 4097, where it must be clear. The valid-charge boundary is found the same way. At 95 % efficiency, 270 strobes give 256 counts and 271 give 257.

// File: rtl/charge_ledger_pkg.sv
package charge_ledger_pkg;
  localparam int TEMP_W  = 4;
  localparam int PCT_W   = 7;
  localparam int SHIFT_W = 3;
  // first temperature code at or above 0 C
  localparam logic [TEMP_W-1:0] CODE_FREEZE = 4'd4;

  // charge efficiency in percent, by regime and temperature band
  function automatic logic [PCT_W-1:0] eff_pct(input logic fast,
                                               input logic [TEMP_W-1:0] code);
    logic [PCT_W-1:0] base;
    if (code <= 4'd6)      base = 7'd80;
    else if (code <= 4'd8) base = 7'd75;
    else                   base = 7'd70;
    return fast ? base + 7'd15 : base;
  endfunction

  // right shift of the self-discharge threshold per temperature step
  function automatic logic [SHIFT_W-1:0] sd_shift(input logic [TEMP_W-1:0] code);
    if (code <= 4'd4)       return 3'd0;
    else if (code >= 4'd11) return 3'd7;
    else                    return 3'(code - 4'd4);
  endfunction
endpackage

// File: rtl/cl_eff_scaler.sv
module cl_eff_scaler #(
  parameter int PCT_W = 7,
  parameter int FULL  = 100
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             strobe_i,
  input  logic [PCT_W-1:0] pct_i,
  output logic             pulse_o
);
  localparam int AW = PCT_W + 1;

  logic [AW-1:0] acc_q, sum;

  always_comb sum = acc_q + AW'(pct_i);

  always_ff @(posedge clk) begin
    if (clr) begin
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (strobe_i) begin
        if (sum >= AW'(FULL)) begin
          acc_q   <= sum - AW'(FULL);
          pulse_o <= 1'b1;
        end else begin
          acc_q <= sum;
        end
      end
    end
  end

  assert_eff_pulse_src_R8: assert property (@(posedge clk) disable iff (clr)
    pulse_o |-> $past(strobe_i));
  assert_eff_acc_bound_R8: assert property (@(posedge clk) disable iff (clr)
    acc_q < AW'(FULL));
endmodule

// File: rtl/cl_sd_timer.sv
module cl_sd_timer #(
  parameter int CW      = 16,
  parameter int SD_DEN  = 1280,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic [CW-1:0]      nac_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               pulse_o
);
  localparam int AW = CW + 1;
  localparam logic [AW-1:0] THR_BASE = AW'(SD_DEN * 4);

  logic [AW-1:0] thr, acc_q, sum, rem;

  always_comb begin
    thr = THR_BASE >> shift_i;
    sum = acc_q + AW'(nac_i);
    rem = sum - thr;
    if (rem >= thr) rem = thr - AW'(1);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick_i && en_i) begin
        if (sum >= thr) begin
          acc_q   <= rem;
          pulse_o <= 1'b1;
        end else begin
          acc_q <= sum;
        end
      end
    end
  end

  assert_sd_pulse_src_R9: assert property (@(posedge clk) disable iff (clr)
    pulse_o |-> $past(tick_i && en_i));
  assert_sd_acc_bound_R9: assert property (@(posedge clk) disable iff (clr)
    acc_q <= THR_BASE);
endmodule

// File: rtl/charge_ledger.sv
module charge_ledger
  import charge_ledger_pkg::*;
#(
  parameter int CW       = 16,
  parameter int SD_DEN   = 1280,
  parameter int VC_LIMIT = 256,
  parameter int SD_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_req,
  input  logic [CW-1:0]     full_count,
  input  logic              load_full,
  input  logic              sd_enable,
  input  logic              chg_strobe,
  input  logic              fast_chg,
  input  logic              dis_strobe,
  input  logic              sd_tick,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              low_v_det,
  output logic [CW-1:0]     avail_cnt,
  output logic [CW-1:0]     drain_cnt,
  output logic [CW-1:0]     learned_cap,
  output logic              flag_qual,
  output logic              flag_empty,
  output logic              flag_charging,
  output logic              flag_replaced
);
  localparam int RUN_W = $clog2(VC_LIMIT + 2);
  localparam int SDC_W = $clog2(SD_LIMIT + 2);

  logic               rst_any;
  logic               chg_pulse, sd_pulse;
  logic [PCT_W-1:0]   pct;
  logic [SHIFT_W-1:0] shift;
  logic [RUN_W-1:0]   run_q;
  logic [SDC_W-1:0]   sdc_q;
  logic at_full, at_zero, sd_dec, drop, valid_evt, learn, cold_empty;

  assign rst_any = rst | init_req;
  assign pct     = eff_pct(fast_chg, temp_code);
  assign shift   = sd_shift(temp_code);

  cl_eff_scaler #(.PCT_W(PCT_W)) u_eff (
    .clk(clk), .clr(rst_any), .strobe_i(chg_strobe), .pct_i(pct), .pulse_o(chg_pulse)
  );

  cl_sd_timer #(.CW(CW), .SD_DEN(SD_DEN), .SHIFT_W(SHIFT_W)) u_sd (
    .clk(clk), .clr(rst_any), .tick_i(sd_tick), .en_i(sd_enable),
    .nac_i(avail_cnt), .shift_i(shift), .pulse_o(sd_pulse)
  );

  always_comb begin
    at_full    = (avail_cnt == learned_cap);
    at_zero    = (avail_cnt == '0);
    sd_dec     = sd_pulse & ~at_zero;
    drop       = dis_strobe | sd_dec;
    valid_evt  = chg_pulse && (run_q == RUN_W'(VC_LIMIT));
    learn      = chg_pulse && flag_empty && flag_qual;
    cold_empty = low_v_det && !flag_empty && (temp_code < CODE_FREEZE);
  end

  // available charge
  always_ff @(posedge clk) begin
    if (rst_any)                      avail_cnt <= load_full ? full_count : '0;
    else if (valid_evt && flag_empty) avail_cnt <= '0;
    else if (drop) begin
      if (!at_zero) avail_cnt <= avail_cnt - CW'(1);
    end else if (chg_pulse && (avail_cnt < learned_cap))
      avail_cnt <= avail_cnt + CW'(1);
  end

  // drain since full, learned capacity
  always_ff @(posedge clk) begin
    if (rst_any) begin
      drain_cnt   <= '0;
      learned_cap <= full_count;
    end else begin
      if (drop)         drain_cnt <= at_full ? CW'(1)
                                   : ((drain_cnt == '1) ? drain_cnt : drain_cnt + CW'(1));
      else if (at_full) drain_cnt <= '0;
      if (learn) learned_cap <= drain_cnt;
    end
  end

  // valid-charge run and self-discharge tally
  always_ff @(posedge clk) begin
    if (rst_any) begin
      run_q <= '0;
      sdc_q <= '0;
    end else begin
      if (dis_strobe) run_q <= '0;
      else if (chg_pulse && (run_q <= RUN_W'(VC_LIMIT))) run_q <= run_q + RUN_W'(1);
      if (sd_dec)       sdc_q <= at_full ? SDC_W'(1)
                                 : ((sdc_q > SDC_W'(SD_LIMIT)) ? sdc_q : sdc_q + SDC_W'(1));
      else if (at_full) sdc_q <= '0;
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (rst_any) begin
      flag_qual     <= 1'b0;
      flag_empty    <= 1'b0;
      flag_charging <= 1'b0;
      flag_replaced <= 1'b1;
    end else begin
      if (learn || valid_evt || cold_empty || (sdc_q > SDC_W'(SD_LIMIT)))
        flag_qual <= 1'b0;
      else if (dis_strobe && at_full)
        flag_qual <= 1'b1;
      if (valid_evt)      flag_empty <= 1'b0;
      else if (low_v_det) flag_empty <= 1'b1;
      if (dis_strobe)     flag_charging <= 1'b0;
      else if (valid_evt) flag_charging <= 1'b1;
      if (at_full || flag_empty) flag_replaced <= 1'b0;
    end
  end

  assert_avail_no_wrap_R1: assert property (@(posedge clk) disable iff (rst || init_req)
    (avail_cnt == '0) |=> (avail_cnt != '1));
  assert_drain_sat_R2: assert property (@(posedge clk) disable iff (rst || init_req)
    (drain_cnt == '1 && !at_full) |=> (drain_cnt == '1));
  assert_qual_rise_R3: assert property (@(posedge clk) disable iff (rst || init_req)
    $rose(flag_qual) |-> $past(dis_strobe && (avail_cnt == learned_cap)));
  assert_learn_only_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(learned_cap) |-> ($past(rst) || $past(init_req) ||
                               ($past(flag_empty) && $past(flag_qual))));
  assert_empty_hold_R6: assert property (@(posedge clk) disable iff (rst || init_req)
    (flag_empty && !chg_pulse) |=> flag_empty);
  assert_charging_clr_R7: assert property (@(posedge clk) disable iff (rst || init_req)
    dis_strobe |=> !flag_charging);
  assert_replaced_clr_R11: assert property (@(posedge clk) disable iff (rst || init_req)
    at_full |=> !flag_replaced);
endmodule

// File: tb/charge_ledger_tb.sv
module charge_ledger_tb;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1, init_req = 1'b0;
  logic [CW-1:0] full_count = '0;
  logic load_full = 1'b0, sd_enable = 1'b0;
  logic chg_strobe = 1'b0, fast_chg = 1'b0, dis_strobe = 1'b0, sd_tick = 1'b0;
  logic [3:0] temp_code = 4'd6;
  logic low_v_det = 1'b0;
  logic [CW-1:0] avail_cnt, drain_cnt, learned_cap;
  logic flag_qual, flag_empty, flag_charging, flag_replaced;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  charge_ledger #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .init_req(init_req), .full_count(full_count),
    .load_full(load_full), .sd_enable(sd_enable), .chg_strobe(chg_strobe),
    .fast_chg(fast_chg), .dis_strobe(dis_strobe), .sd_tick(sd_tick),
    .temp_code(temp_code), .low_v_det(low_v_det), .avail_cnt(avail_cnt),
    .drain_cnt(drain_cnt), .learned_cap(learned_cap), .flag_qual(flag_qual),
    .flag_empty(flag_empty), .flag_charging(flag_charging), .flag_replaced(flag_replaced)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic reinit(input int pfc, input logic lf);
    @(negedge clk);
    full_count = CW'(pfc); load_full = lf; init_req = 1'b1;
    sd_enable = 1'b0; fast_chg = 1'b1; temp_code = 4'd6; low_v_det = 1'b0;
    @(negedge clk);
    init_req = 1'b0;
    settle();
  endtask

  task automatic charge_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) chg_strobe = 1'b1;
      @(negedge clk) chg_strobe = 1'b0;
    end
    settle();
  endtask

  task automatic discharge_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) dis_strobe = 1'b1;
      @(negedge clk) dis_strobe = 1'b0;
    end
    settle();
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sd_tick = 1'b1;
      @(negedge clk) sd_tick = 1'b0;
      @(negedge clk);
    end
    settle();
  endtask

  task automatic pulse_low_v();
    @(negedge clk) low_v_det = 1'b1;
    @(negedge clk) low_v_det = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    full_count = CW'(1234); load_full = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R10 avail after reset", avail_cnt, 0);
    chk("R10 learned after reset", learned_cap, 1234);
    chk("R10 drain after reset", drain_cnt, 0);
    chk("R10 flags qual/empty/charging", {flag_qual, flag_empty, flag_charging}, 0);
    chk("R11 replaced after reset", flag_replaced, 1);
    reinit(1234, 1'b1);
    chk("R10 avail preload full", avail_cnt, 1234);
    chk("R11 replaced clears at full", flag_replaced, 0);
  endtask

  task automatic t_eff();
    reinit(5000, 1'b0);
    temp_code = 4'd7; fast_chg = 1'b0; charge_n(100);
    chk("R8 trickle 30-40C", avail_cnt, 75);
    temp_code = 4'd10; fast_chg = 1'b1; charge_n(100);
    chk("R8 fast 60-70C", avail_cnt, 160);
    temp_code = 4'd2; fast_chg = 1'b0; charge_n(100);
    chk("R8 trickle cold", avail_cnt, 240);
    temp_code = 4'd6; fast_chg = 1'b1; charge_n(100);
    chk("R8 fast 20-30C", avail_cnt, 335);
  endtask

  task automatic t_clamp();
    reinit(100, 1'b1);
    charge_n(50);
    chk("R1 no rise above learned", avail_cnt, 100);
    chk("R2 drain clear at full", drain_cnt, 0);
    discharge_n(150);
    chk("R1 floor at zero", avail_cnt, 0);
    chk("R2 drain counts past empty", drain_cnt, 150);
    chk("R3 qual set from full", flag_qual, 1);
    sd_enable = 1'b1; temp_code = 4'd12; tick_n(20); sd_enable = 1'b0;
    chk("R2 no self-discharge at zero", drain_cnt, 150);
    temp_code = 4'd6; charge_n(20);
    chk("R1 charge from zero", avail_cnt, 19);
  endtask

  task automatic t_drain_sat();
    reinit(100, 1'b1);
    @(negedge clk) dis_strobe = 1'b1;
    repeat (65600) @(negedge clk);
    dis_strobe = 1'b0;
    settle();
    chk("R2 drain saturates", drain_cnt, 65535);
  endtask

  task automatic t_sd_rate();
    int acc = 0, nac_m = 1000, dcr_m = 0;
    int codes[3] = '{6, 7, 3};
    reinit(1000, 1'b1);
    sd_enable = 1'b1;
    foreach (codes[k]) begin
      int sh = (codes[k] <= 4) ? 0 : (codes[k] >= 11 ? 7 : codes[k] - 4);
      int thr = (1280 * 4) >> sh;
      temp_code = 4'(codes[k]);
      for (int i = 0; i < 40; i++) begin
        int sum = acc + nac_m;
        if (sum >= thr) begin
          acc = (sum - thr >= thr) ? thr - 1 : sum - thr;
          nac_m--; dcr_m++;
        end else acc = sum;
      end
      tick_n(40);
      chk($sformatf("R9 self-discharge code %0d avail", codes[k]), avail_cnt, nac_m);
      chk($sformatf("R9 self-discharge code %0d drain", codes[k]), drain_cnt, dcr_m);
    end
    sd_enable = 1'b0; tick_n(20);
    chk("R9 disabled ticks ignored", avail_cnt, nac_m);
  endtask

  task automatic t_valid_charge();
    reinit(5000, 1'b1);
    discharge_n(1000);
    chk("R3 qual after discharge", flag_qual, 1);
    charge_n(270);
    chk("R4 256 counts keep qual", flag_qual, 1);
    chk("R7 not yet charging", flag_charging, 0);
    chk("R1 avail after 256 counts", avail_cnt, 4256);
    charge_n(1);
    chk("R4 257th count clears qual", flag_qual, 0);
    chk("R7 charging set", flag_charging, 1);
    discharge_n(1);
    chk("R7 discharge clears charging", flag_charging, 0);
  endtask

  task automatic t_sd_limit();
    reinit(60000, 1'b1);
    temp_code = 4'd12;
    discharge_n(1);
    sd_enable = 1'b1;
    tick_n(4096);
    chk("R4 4096 self counts keep qual", flag_qual, 1);
    chk("R9 one count per tick", avail_cnt, 55903);
    tick_n(1);
    chk("R4 4097 self counts clear qual", flag_qual, 0);
    chk("R2 self-discharge into drain", drain_cnt, 4098);
    sd_enable = 1'b0;
  endtask

  task automatic t_learn();
    reinit(500, 1'b1);
    discharge_n(600);
    pulse_low_v();
    chk("R6 empty latched", flag_empty, 1);
    chk("R4 warm end keeps qual", flag_qual, 1);
    charge_n(2);
    chk("R5 learned from drain", learned_cap, 600);
    chk("R5 qual cleared by learning", flag_qual, 0);
    charge_n(298);
    chk("R6 valid charge zeroes avail", avail_cnt, 28);
    chk("R6 valid charge clears empty", flag_empty, 0);
  endtask

  task automatic t_cold();
    reinit(500, 1'b1);
    discharge_n(600);
    temp_code = 4'd3;
    pulse_low_v();
    chk("R4 cold end clears qual", flag_qual, 0);
    temp_code = 4'd6;
    charge_n(10);
    chk("R5 no learning after cold end", learned_cap, 500);
  endtask

  task automatic t_empty();
    reinit(5000, 1'b0);
    chk("R11 replaced before empty", flag_replaced, 1);
    pulse_low_v();
    chk("R11 empty clears replaced", flag_replaced, 0);
    charge_n(200);
    chk("R6 empty holds below valid", flag_empty, 1);
    chk("R1 counts while empty", avail_cnt, 190);
    charge_n(100);
    chk("R6 empty cleared by valid charge", flag_empty, 0);
    chk("R6 avail restarts from zero", avail_cnt, 28);
    chk("R5 learned untouched without qual", learned_cap, 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_eff();
    t_clamp();
    t_valid_charge();
    t_learn();
    t_cold();
    t_empty();
    t_sd_rate();
    t_sd_limit();
    t_drain_sat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule